// File: doc/BRIEF.md
# Gigabit Fiber Link Auto-Negotiation Controller

This block runs the configuration exchange for a 1000 Mb/s serial fiber link without software help. It builds a 16-bit local advertisement from static local settings and hands it to the symbol layer, which places it in configuration ordered sets. It also watches the configuration words that arrive from the link partner. The exchange moves through these stages in order: restart, ability detect, acknowledge detect, complete-acknowledge, idle detect and link-ok. A link timer sets the length of the restart, complete-acknowledge and idle-detect stages.

When the block reaches link-ok, it raises a completion flag. It also reports the resolved duplex, the pause enables resolved from both partners' pause bits, and the partner's raw pause abilities. These resolved values take precedence over any locally configured mode. Next-page exchange takes place only when both partners request it. In that case the block sends one null next page and drops the content of the partner's next page, so the reported results always come from the base pages.

The surrounding symbol layer supplies a received word with a valid strobe, the receiver sync state and an idle indication. It takes from this block the word to send and a flag that chooses between sending configuration sets and sending idles.

Top module: `fiber_an_ctrl`

## Requirements
- R1: While `an_enable` is low, `tx_send_cfg` and `an_complete` are low.
- R2: After any restart, the block sends all-zero configuration words (`tx_send_cfg`=1, `tx_cfg_word`=0) for at least LINK_TIMER_CYCLES and at most twice that many cycles. It then advertises the local word.
- R3: A restart is caused by `link_reset` falling from 1 to 0, by `an_enable` rising, or by `sync_ok` rising while `an_enable` is high. While `link_reset` is high or `sync_ok` is low (and enabled), the block stays in restart, sending zero words.
- R4: If a configuration word arrives (`rx_cfg_valid`) while in link-ok, `an_complete` drops on the next cycle and a restart begins.
- R5: In the acknowledge or complete-acknowledge stages, a received word that differs from the accepted ability (bit 14 excluded) causes a restart.
- R6: Transmit word layout: bit 5 full duplex, bit 6 half duplex, bit 7 symmetric pause, bit 8 asymmetric pause, bits 13:12 from `loc_remote_fault`, bit 14 acknowledge, bit 15 next-page request. Bits 11:9 and 4:0 are zero.
- R7: A partner word is accepted only after MATCH_COUNT (3) consecutive equal, non-zero words, with bit 14 excluded from the comparison. Only after that does the block set bit 14 in its transmit word.
- R8: The block enters the complete-acknowledge stage after three consecutive matching words that have bit 14 set. After one link-timer period it switches to idles (`tx_send_cfg`=0). After a further link-timer period, with an idle seen, `an_complete` rises. `an_complete` is high only in link-ok, and the acknowledge bit is set in the last configuration word sent.
- R9: The resolved duplex is full if both partners advertise full. Otherwise it is half if both advertise half. Otherwise neither flag is set.
- R10: Pause resolution works as follows. Both partners symmetric gives transmit and receive pause. Local asymmetric-only with a partner advertising both gives transmit only. Local both with a partner advertising asymmetric-only gives receive only. All other cases give no pause. The partner's raw pause bits are also reported.
- R11: When both base pages have bit 15 set, the block sends the null next page 16'h2801 (16'h6801 with acknowledge) and ignores the partner's next-page content. Otherwise it never sends a next page.
- R12: All result outputs are zero whenever `an_complete` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| an_enable | input | 1 | Enables hardware negotiation |
| link_reset | input | 1 | Holds negotiation in restart while high |
| sync_ok | input | 1 | Receiver is synchronized |
| rx_cfg_valid | input | 1 | A received configuration word is present |
| rx_cfg_word | input | 16 | Received configuration word |
| rx_idle | input | 1 | An idle ordered set was received |
| loc_full_duplex | input | 1 | Local full-duplex ability |
| loc_half_duplex | input | 1 | Local half-duplex ability |
| loc_sym_pause | input | 1 | Local symmetric pause ability |
| loc_asym_pause | input | 1 | Local asymmetric pause ability |
| loc_next_page | input | 1 | Local next-page request |
| loc_remote_fault | input | 2 | Remote-fault code to advertise |
| tx_cfg_word | output | 16 | Configuration word to send |
| tx_send_cfg | output | 1 | 1 = send configuration sets, 0 = send idles |
| an_complete | output | 1 | Negotiation finished, link-ok |
| res_full_duplex | output | 1 | Resolved full duplex |
| res_half_duplex | output | 1 | Resolved half duplex |
| res_pause_tx | output | 1 | Resolved: may send pause frames |
| res_pause_rx | output | 1 | Resolved: honours received pause frames |
| partner_sym_pause | output | 1 | Partner symmetric pause bit |
| partner_asym_pause | output | 1 | Partner asymmetric pause bit |

## Verification
The key collision is between the acknowledge tracking and the restart trigger. Both act on the same received-word strobe: one word can either extend an acknowledge run or, if its content differs, abort the exchange. The bench provokes this in three ways. It breaks a run of matching words after two entries. It injects a changed word right after the ability is accepted. It sends a configuration word while in link-ok. In each case it judges on the next sampled cycle whether the transmit word holds its acknowledge bit or falls back to all-zero restart words.

// File: rtl/fan_pkg.sv
package fan_pkg;

    localparam int WORD_W = 16;
    localparam int B_FD   = 5;
    localparam int B_HD   = 6;
    localparam int B_PS   = 7;
    localparam int B_AS   = 8;
    localparam int B_RF   = 12;
    localparam int B_ACK  = 14;
    localparam int B_NP   = 15;

    // null message page: message-page bit, toggle bit, null code
    localparam logic [WORD_W-1:0] NULL_PAGE = 16'h2801;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RESTART,
        ST_ABIL,
        ST_ACK,
        ST_CACK,
        ST_IDLE,
        ST_LINK
    } an_state_e;

    typedef struct packed {
        logic       np;
        logic [1:0] rfault;
        logic       asym;
        logic       sym;
        logic       hd;
        logic       fd;
    } adv_t;

    typedef struct packed {
        logic full;
        logic half;
        logic ptx;
        logic prx;
    } result_t;

    function automatic logic [WORD_W-1:0] pack_adv(input adv_t a);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[B_FD]     = a.fd;
        w[B_HD]     = a.hd;
        w[B_PS]     = a.sym;
        w[B_AS]     = a.asym;
        w[B_RF+:2]  = a.rfault;
        w[B_NP]     = a.np;
        return w;
    endfunction

    function automatic adv_t unpack_adv(input logic [WORD_W-1:0] w);
        adv_t a;
        a.fd     = w[B_FD];
        a.hd     = w[B_HD];
        a.sym    = w[B_PS];
        a.asym   = w[B_AS];
        a.rfault = w[B_RF+:2];
        a.np     = w[B_NP];
        return a;
    endfunction

    function automatic logic [WORD_W-1:0] drop_ack(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] m;
        m        = w;
        m[B_ACK] = 1'b0;
        return m;
    endfunction

    function automatic result_t resolve(input adv_t l, input adv_t p);
        result_t r;
        r.full = l.fd & p.fd;
        r.half = ~r.full & l.hd & p.hd;
        r.ptx  = 1'b0;
        r.prx  = 1'b0;
        if (l.sym && p.sym) begin
            r.ptx = 1'b1;
            r.prx = 1'b1;
        end else if (!l.sym && l.asym && p.sym && p.asym) begin
            r.ptx = 1'b1;
        end else if (l.sym && l.asym && !p.sym && p.asym) begin
            r.prx = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/fan_link_timer.sv
module fan_link_timer #(
    parameter int unsigned LIMIT = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fan_rx_matcher.sv
module fan_rx_matcher
    import fan_pkg::*;
#(
    parameter int MATCH_N = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output logic              ability_match,
    output logic              ack_match,
    output logic              diff_word,
    output logic [WORD_W-1:0] matched
);
    localparam int RUN_W = $clog2(MATCH_N + 1);

    logic [WORD_W-1:0] track_q;
    logic [RUN_W-1:0]  same_q;
    logic [RUN_W-1:0]  ackrun_q;
    logic [WORD_W-1:0] masked;
    logic              same;

    assign masked        = drop_ack(word);
    assign same          = (same_q != '0) && (masked == track_q);
    assign ability_match = (same_q == RUN_W'(MATCH_N));
    assign ack_match     = (ackrun_q == RUN_W'(MATCH_N));
    assign diff_word     = valid && ability_match && !same;
    assign matched       = track_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            track_q  <= '0;
            same_q   <= '0;
            ackrun_q <= '0;
        end else if (valid) begin
            if (same) begin
                if (!ability_match) begin
                    same_q <= same_q + 1'b1;
                end
                if (!word[B_ACK]) begin
                    ackrun_q <= '0;
                end else if (!ack_match) begin
                    ackrun_q <= ackrun_q + 1'b1;
                end
            end else begin
                track_q  <= masked;
                same_q   <= RUN_W'(1);
                ackrun_q <= word[B_ACK] ? RUN_W'(1) : '0;
            end
        end
    end
endmodule

// File: rtl/fan_restart_src.sv
module fan_restart_src (
    input  logic clk,
    input  logic rst,
    input  logic an_enable,
    input  logic link_reset,
    input  logic sync_ok,
    output logic ctrl_trig,
    output logic hold
);
    logic en_q;
    logic lrst_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            lrst_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            en_q   <= an_enable;
            lrst_q <= link_reset;
            sync_q <= sync_ok;
        end
    end

    assign ctrl_trig = (an_enable && !en_q)
                     || (!link_reset && lrst_q)
                     || (an_enable && sync_ok && !sync_q);
    assign hold      = link_reset || !sync_ok;
endmodule

// File: rtl/fan_seq.sv
module fan_seq
    import fan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              an_enable,
    input  logic              ctrl_trig,
    input  logic              hold,
    input  logic              rx_cfg_valid,
    input  logic              rx_idle,
    input  logic              ability_match,
    input  logic              ack_match,
    input  logic              diff_word,
    input  logic [WORD_W-1:0] matched,
    input  logic              timer_done,
    input  logic              loc_np,
    output an_state_e         state,
    output logic              np_phase,
    output logic              timer_start,
    output logic              matcher_clr,
    output logic [WORD_W-1:0] partner
);
    an_state_e         state_q;
    an_state_e         state_d;
    logic              go_restart;
    logic              np_q;
    logic              idle_seen_q;
    logic [WORD_W-1:0] partner_q;

    always_comb begin
        state_d    = state_q;
        go_restart = 1'b0;
        case (state_q)
            ST_RESTART: if (timer_done) state_d = ST_ABIL;
            ST_ABIL:    if (ability_match && matched != '0) state_d = ST_ACK;
            ST_ACK: begin
                if (diff_word)      go_restart = 1'b1;
                else if (ack_match) state_d = ST_CACK;
            end
            ST_CACK: begin
                if (diff_word) begin
                    go_restart = 1'b1;
                end else if (timer_done) begin
                    state_d = (!np_q && loc_np && partner_q[B_NP]) ? ST_ABIL : ST_IDLE;
                end
            end
            ST_IDLE:    if (timer_done && (idle_seen_q || rx_idle)) state_d = ST_LINK;
            ST_LINK:    if (rx_cfg_valid) go_restart = 1'b1;
            default: ;
        endcase
        if (ctrl_trig || hold) go_restart = 1'b1;
        if (go_restart) state_d = ST_RESTART;
        if (!an_enable) begin
            state_d    = ST_OFF;
            go_restart = 1'b0;
        end
    end

    assign timer_start = go_restart || (state_d != state_q);
    assign matcher_clr = (state_q == ST_OFF) || (state_q == ST_RESTART)
                       || (state_q == ST_CACK && state_d == ST_ABIL);
    assign state       = state_q;
    assign np_phase    = np_q;
    assign partner     = partner_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_OFF;
            np_q        <= 1'b0;
            idle_seen_q <= 1'b0;
            partner_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_RESTART || state_d == ST_OFF) begin
                np_q <= 1'b0;
            end else if (state_q == ST_CACK && state_d == ST_ABIL) begin
                np_q <= 1'b1;
            end
            if (timer_start)  idle_seen_q <= 1'b0;
            else if (rx_idle) idle_seen_q <= 1'b1;
            // only base pages update the partner view; next pages are dropped
            if (state_q == ST_ABIL && state_d == ST_ACK && !np_q) begin
                partner_q <= matched;
            end
        end
    end
endmodule

// File: rtl/fiber_an_ctrl.sv
module fiber_an_ctrl
    import fan_pkg::*;
#(
    parameter int unsigned LINK_TIMER_CYCLES = 1250000,
    parameter int          MATCH_COUNT       = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        an_enable,
    input  logic        link_reset,
    input  logic        sync_ok,
    input  logic        rx_cfg_valid,
    input  logic [15:0] rx_cfg_word,
    input  logic        rx_idle,
    input  logic        loc_full_duplex,
    input  logic        loc_half_duplex,
    input  logic        loc_sym_pause,
    input  logic        loc_asym_pause,
    input  logic        loc_next_page,
    input  logic [1:0]  loc_remote_fault,
    output logic [15:0] tx_cfg_word,
    output logic        tx_send_cfg,
    output logic        an_complete,
    output logic        res_full_duplex,
    output logic        res_half_duplex,
    output logic        res_pause_tx,
    output logic        res_pause_rx,
    output logic        partner_sym_pause,
    output logic        partner_asym_pause
);
    logic              ctrl_trig;
    logic              hold;
    logic              timer_start;
    logic              timer_done;
    logic              matcher_clr;
    logic              ability_match;
    logic              ack_match;
    logic              diff_word;
    logic [WORD_W-1:0] matched;
    logic [WORD_W-1:0] partner;
    logic              np_phase;
    an_state_e         state;
    adv_t              local_adv;
    adv_t              partner_adv;
    result_t           res;
    logic [WORD_W-1:0] page;

    fan_restart_src i_src (
        .clk        (clk),
        .rst        (rst),
        .an_enable  (an_enable),
        .link_reset (link_reset),
        .sync_ok    (sync_ok),
        .ctrl_trig  (ctrl_trig),
        .hold       (hold)
    );

    fan_link_timer #(.LIMIT(LINK_TIMER_CYCLES)) i_timer (
        .clk   (clk),
        .rst   (rst),
        .start (timer_start),
        .done  (timer_done)
    );

    fan_rx_matcher #(.MATCH_N(MATCH_COUNT)) i_match (
        .clk           (clk),
        .rst           (rst),
        .clr           (matcher_clr),
        .valid         (rx_cfg_valid),
        .word          (rx_cfg_word),
        .ability_match (ability_match),
        .ack_match     (ack_match),
        .diff_word     (diff_word),
        .matched       (matched)
    );

    fan_seq i_seq (
        .clk           (clk),
        .rst           (rst),
        .an_enable     (an_enable),
        .ctrl_trig     (ctrl_trig),
        .hold          (hold),
        .rx_cfg_valid  (rx_cfg_valid),
        .rx_idle       (rx_idle),
        .ability_match (ability_match),
        .ack_match     (ack_match),
        .diff_word     (diff_word),
        .matched       (matched),
        .timer_done    (timer_done),
        .loc_np        (loc_next_page),
        .state         (state),
        .np_phase      (np_phase),
        .timer_start   (timer_start),
        .matcher_clr   (matcher_clr),
        .partner       (partner)
    );

    assign local_adv.np     = loc_next_page;
    assign local_adv.rfault = loc_remote_fault;
    assign local_adv.asym   = loc_asym_pause;
    assign local_adv.sym    = loc_sym_pause;
    assign local_adv.hd     = loc_half_duplex;
    assign local_adv.fd     = loc_full_duplex;

    assign partner_adv = unpack_adv(partner);
    assign res         = resolve(local_adv, partner_adv);
    assign page        = np_phase ? NULL_PAGE : pack_adv(local_adv);

    always_comb begin
        tx_cfg_word = '0;
        tx_send_cfg = 1'b0;
        case (state)
            ST_RESTART: tx_send_cfg = 1'b1;
            ST_ABIL: begin
                tx_send_cfg = 1'b1;
                tx_cfg_word = page;
            end
            ST_ACK, ST_CACK: begin
                tx_send_cfg        = 1'b1;
                tx_cfg_word        = page;
                tx_cfg_word[B_ACK] = 1'b1;
            end
            default: ;
        endcase
    end

    assign an_complete        = (state == ST_LINK);
    assign res_full_duplex    = an_complete & res.full;
    assign res_half_duplex    = an_complete & res.half;
    assign res_pause_tx       = an_complete & res.ptx;
    assign res_pause_rx       = an_complete & res.prx;
    assign partner_sym_pause  = an_complete & partner_adv.sym;
    assign partner_asym_pause = an_complete & partner_adv.asym;
endmodule

// File: rtl/fiber_an_ctrl_chk.sv
module fiber_an_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        an_enable,
    input logic        link_reset,
    input logic        sync_ok,
    input logic        rx_cfg_valid,
    input logic [15:0] tx_cfg_word,
    input logic        tx_send_cfg,
    input logic        an_complete
);
    a_r1_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        !an_enable |=> (!tx_send_cfg && !an_complete));

    a_r2_zero_words_first: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_send_cfg) |-> (tx_cfg_word == 16'h0000));

    a_r3_held_in_restart: assert property (@(posedge clk) disable iff (rst)
        (an_enable && (link_reset || !sync_ok)) |=>
            (tx_send_cfg && tx_cfg_word == 16'h0000 && !an_complete));

    a_r4_cfg_in_link_restarts: assert property (@(posedge clk) disable iff (rst)
        (an_enable && an_complete && rx_cfg_valid) |=> (!an_complete && tx_send_cfg));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        tx_send_cfg |-> ((tx_cfg_word[11:9] == 3'b000 && tx_cfg_word[4:0] == 5'b00000)
                         || ((tx_cfg_word & 16'hBFFF) == 16'h2801)));

    a_r8_idles_when_complete: assert property (@(posedge clk) disable iff (rst)
        an_complete |-> !tx_send_cfg);

    a_r8_ack_before_idles: assert property (@(posedge clk) disable iff (rst)
        ($fell(tx_send_cfg) && $past(an_enable)) |-> $past(tx_cfg_word[14]));
endmodule

bind fiber_an_ctrl fiber_an_ctrl_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .an_enable    (an_enable),
    .link_reset   (link_reset),
    .sync_ok      (sync_ok),
    .rx_cfg_valid (rx_cfg_valid),
    .tx_cfg_word  (tx_cfg_word),
    .tx_send_cfg  (tx_send_cfg),
    .an_complete  (an_complete)
);

// File: tb/test_fiber_an_ctrl.sv
`timescale 1ns/1ps
module test_fiber_an_ctrl;
    localparam int unsigned LT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        an_enable = 1'b0;
    logic        link_reset = 1'b0;
    logic        sync_ok = 1'b1;
    logic        rx_cfg_valid = 1'b0;
    logic [15:0] rx_cfg_word = '0;
    logic        rx_idle = 1'b0;
    logic        loc_full_duplex = 1'b0;
    logic        loc_half_duplex = 1'b0;
    logic        loc_sym_pause = 1'b0;
    logic        loc_asym_pause = 1'b0;
    logic        loc_next_page = 1'b0;
    logic [1:0]  loc_remote_fault = 2'b00;
    logic [15:0] tx_cfg_word;
    logic        tx_send_cfg;
    logic        an_complete;
    logic        res_full_duplex;
    logic        res_half_duplex;
    logic        res_pause_tx;
    logic        res_pause_rx;
    logic        partner_sym_pause;
    logic        partner_asym_pause;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] last_ack_word = '0;
    logic        saw_null = 1'b0;

    always #2.5 clk = ~clk;

    fiber_an_ctrl #(.LINK_TIMER_CYCLES(LT), .MATCH_COUNT(3)) i_fiber_an_ctrl (
        .clk(clk), .rst(rst), .an_enable(an_enable), .link_reset(link_reset),
        .sync_ok(sync_ok), .rx_cfg_valid(rx_cfg_valid), .rx_cfg_word(rx_cfg_word),
        .rx_idle(rx_idle), .loc_full_duplex(loc_full_duplex),
        .loc_half_duplex(loc_half_duplex), .loc_sym_pause(loc_sym_pause),
        .loc_asym_pause(loc_asym_pause), .loc_next_page(loc_next_page),
        .loc_remote_fault(loc_remote_fault), .tx_cfg_word(tx_cfg_word),
        .tx_send_cfg(tx_send_cfg), .an_complete(an_complete),
        .res_full_duplex(res_full_duplex), .res_half_duplex(res_half_duplex),
        .res_pause_tx(res_pause_tx), .res_pause_rx(res_pause_rx),
        .partner_sym_pause(partner_sym_pause), .partner_asym_pause(partner_asym_pause)
    );

    always @(negedge clk) begin
        if (tx_send_cfg && (tx_cfg_word == 16'h2801 || tx_cfg_word == 16'h6801)) saw_null <= 1'b1;
    end

    // {loc fd,hd,ps,as | partner fd,hd,ps,as | exp full,half,ptx,prx}
    localparam logic [11:0] VEC [0:5] = '{
        12'b1111_1111_1011,
        12'b1110_0100_0100,
        12'b1001_1011_1010,
        12'b1111_1001_1001,
        12'b0110_1010_0011,
        12'b1001_1001_1000
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        rx_cfg_valid = 1'b1;
        rx_cfg_word  = w;
        @(negedge clk);
        rx_cfg_valid = 1'b0;
    endtask

    task automatic wait_abil();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tx_send_cfg && tx_cfg_word != 16'h0 && !tx_cfg_word[14]) break;
        end
    endtask

    task automatic exchange(input logic [15:0] w);
        for (int i = 0; i < 50; i++) begin
            if (tx_cfg_word[14]) break;
            send_word(w);
        end
        last_ack_word = tx_cfg_word;
        for (int i = 0; i < 100; i++) begin
            if (!(tx_send_cfg && tx_cfg_word[14])) break;
            send_word(w | 16'h4000);
        end
    endtask

    task automatic finish_idle();
        rx_idle = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (an_complete) break;
        end
        rx_idle = 1'b0;
    endtask

    task automatic negotiate(input logic [15:0] pw);
        wait_abil();
        exchange(pw);
        finish_idle();
    endtask

    task automatic reenable();
        @(negedge clk);
        an_enable = 1'b0;
        repeat (2) @(negedge clk);
        an_enable = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int rcnt;
        logic [15:0] pw;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R12: reset state with negotiation disabled
        check(!tx_send_cfg && !an_complete, "R1 reset idle", {tx_send_cfg, an_complete}, 0);
        check({res_full_duplex, res_half_duplex, res_pause_tx, res_pause_rx} == 0, "R12 results zero", 0, 0);

        // R2: restart length and R6 layout
        loc_full_duplex = 1; loc_half_duplex = 1; loc_sym_pause = 1; loc_asym_pause = 0;
        loc_remote_fault = 2'b10;
        an_enable = 1'b1;
        rcnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tx_send_cfg && tx_cfg_word == 16'h0) rcnt++;
            else if (rcnt > 0) break;
        end
        check(rcnt >= LT && rcnt <= 2 * LT, "R2 restart length", rcnt, LT);
        check(tx_cfg_word == 16'h20E0, "R6 advertised layout", tx_cfg_word, 16'h20E0);

        // R7: broken run does not acknowledge
        send_word(16'h01A0); send_word(16'h01A0); send_word(16'h0060);
        check(!tx_cfg_word[14], "R7 no ack after broken run", tx_cfg_word, 16'h20E0);
        send_word(16'h0060);
        check(!tx_cfg_word[14], "R7 no ack after two", tx_cfg_word, 16'h20E0);
        send_word(16'h0060);
        @(negedge clk);
        check(tx_cfg_word == 16'h60E0, "R7 ack after three", tx_cfg_word, 16'h60E0);

        // R5: changed word during acknowledge restarts
        send_word(16'h0040);
        check(tx_send_cfg && tx_cfg_word == 16'h0 && !an_complete, "R5 mismatch restart", tx_cfg_word, 0);

        // R8: full exchange
        negotiate(16'h0060);
        check(an_complete, "R8 complete", an_complete, 1);
        check(!tx_send_cfg, "R8 idles at link ok", tx_send_cfg, 0);
        check(res_full_duplex && !res_half_duplex, "R9 full duplex", {res_full_duplex, res_half_duplex}, 2'b10);

        // R4: config word in link-ok
        send_word(16'h4060);
        check(!an_complete && tx_send_cfg && tx_cfg_word == 16'h0, "R4 cfg in link restarts", {an_complete, tx_send_cfg}, 2'b01);
        check(!res_full_duplex, "R12 results cleared", res_full_duplex, 0);

        // R3: link reset hold and release
        negotiate(16'h0060);
        check(an_complete, "R3 pre link reset", an_complete, 1);
        link_reset = 1'b1;
        @(negedge clk);
        check(!an_complete && tx_send_cfg && tx_cfg_word == 0, "R3 link reset", tx_cfg_word, 0);
        repeat (3 * LT) @(negedge clk);
        check(tx_send_cfg && tx_cfg_word == 0, "R3 held while reset", tx_cfg_word, 0);
        link_reset = 1'b0;
        @(negedge clk);
        check(tx_send_cfg && tx_cfg_word == 0, "R3 restart after release", tx_cfg_word, 0);
        negotiate(16'h0060);
        check(an_complete, "R3 renegotiated", an_complete, 1);

        // R3: sync loss and regain
        sync_ok = 1'b0;
        @(negedge clk);
        check(!an_complete && tx_send_cfg, "R3 sync loss", an_complete, 0);
        repeat (3) @(negedge clk);
        sync_ok = 1'b1;
        @(negedge clk);
        check(tx_send_cfg && tx_cfg_word == 0, "R3 sync regain restart", tx_cfg_word, 0);

        // R1 / R3: disabled, sync regain does nothing
        an_enable = 1'b0;
        @(negedge clk);
        check(!tx_send_cfg && !an_complete, "R1 disabled", tx_send_cfg, 0);
        sync_ok = 1'b0;
        repeat (2) @(negedge clk);
        sync_ok = 1'b1;
        repeat (2) @(negedge clk);
        check(!tx_send_cfg, "R3 sync rise ignored when off", tx_send_cfg, 0);

        // R9 / R10: resolution table
        loc_remote_fault = 2'b00;
        for (int v = 0; v < 6; v++) begin
            {loc_full_duplex, loc_half_duplex, loc_sym_pause, loc_asym_pause} = VEC[v][11:8];
            pw = {7'b0, VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7], 5'b0};
            reenable();
            negotiate(pw);
            check(an_complete, "R8 vector complete", an_complete, 1);
            check({res_full_duplex, res_half_duplex} == VEC[v][3:2], "R9 duplex",
                  {res_full_duplex, res_half_duplex}, VEC[v][3:2]);
            check({res_pause_tx, res_pause_rx} == VEC[v][1:0], "R10 pause",
                  {res_pause_tx, res_pause_rx}, VEC[v][1:0]);
            check({partner_sym_pause, partner_asym_pause} == {VEC[v][5], VEC[v][4]}, "R10 partner pause",
                  {partner_sym_pause, partner_asym_pause}, {VEC[v][5], VEC[v][4]});
        end

        // R11: both request next page
        {loc_full_duplex, loc_half_duplex, loc_sym_pause, loc_asym_pause} = 4'b1010;
        loc_next_page = 1'b1;
        reenable();
        wait_abil();
        exchange(16'h80A0);
        check(tx_send_cfg && tx_cfg_word == 16'h2801, "R11 null page sent", tx_cfg_word, 16'h2801);
        exchange(16'h0140);
        check(last_ack_word == 16'h6801, "R11 null page ack", last_ack_word, 16'h6801);
        finish_idle();
        check(an_complete, "R11 complete after next page", an_complete, 1);
        check(partner_sym_pause && !partner_asym_pause && res_full_duplex, "R11 next page dropped",
              {partner_sym_pause, partner_asym_pause, res_full_duplex}, 3'b101);

        // R11: only local request, no next page
        reenable();
        saw_null = 1'b0;
        negotiate(16'h00A0);
        check(an_complete, "R11 single request complete", an_complete, 1);
        check(!saw_null, "R11 no null page", saw_null, 0);

        summary();
        $finish;
    end
endmodule